// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an EDO DRAM module up from cold and keeps its contents alive afterwards. After reset it stays quiet for the power-up pause. It then asks the access sequencer for the bus and runs a fixed number of initialization cycles back to back. Every one of these cycles is a CAS-before-RAS refresh. When the last of them ends, the block raises its ready output. The memory may then be used.

From then on an interval timer, derived from the clock frequency, the retention time and the row count, marks when the next refresh is due. Each due refresh is recorded in a small backlog counter. The block requests the bus until the backlog is empty. A refresh that comes due while the bus is withheld is kept and never lost. Once granted, the block drives every RAS and every CAS line together, so both sides of the module are refreshed in one cycle. Write enable stays high for the whole cycle. The strobe sequence is: precharge, CAS low, RAS low, CAS high, recovery. Each phase lasts a cycle count computed from nanosecond limits.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is applied and on the first cycle after it, all `ras_n` and `cas_n` lines are high, `we_n` is high, and `strobe_oe`, `bus_req` and `mem_ready` are low.
- R2: `bus_req` stays low for the first PAUSE_CYC = CLK_MHZ*PAUSE_US clock edges after reset release (10000 by default). It goes high right after that edge.
- R3: The block runs exactly INIT_CYCLES refresh cycles (8 by default) before `mem_ready` rises. `mem_ready` rises on the edge that ends the last of them. Under a constant grant this edge is PAUSE_CYC + 9*INIT_CYCLES edges after reset release. `mem_ready` then stays high until reset.
- R4: Each refresh cycle lasts 8 clocks by default. It runs: RP_CYC clocks with RAS and CAS high; CSR_CYC clocks with CAS low and RAS high; CHR_CYC clocks with both low; then CAS high and RAS low until RAS has been low for RAS_CYC clocks; then RP_CYC clocks with both high. Cycle counts are the nanosecond limits rounded up at CLK_MHZ and are at least 1 (RP 2, CSR 1, CHR 1, RAS 3 by default). All RAS lines carry the same level, and so do all CAS lines.
- R5: `we_n` is high on every cycle.
- R6: A refresh cycle starts only on an edge where `bus_req` and `bus_gnt` are both high and no cycle is running. Its first precharge clock follows that edge. `strobe_oe` is high exactly during the cycle's clocks. A grant without a request has no effect, and the grant is not looked at while a cycle runs.
- R7: Once raised, `bus_req` stays high until the edge that ends the last owed cycle. Between cycles owed back to back, the block is idle for one clock while still requesting.
- R8: After `mem_ready`, a refresh comes due every REF_CYC = CLK_MHZ*RETENTION_US/ROWS edges (781 by default). The timer starts when the block becomes ready. Under a prompt grant, successive refresh cycles start exactly REF_CYC clocks apart.
- R9: Refreshes that come due while the grant is withheld build up to PEND_MAX (3 by default) and are then issued back to back once granted. Further refreshes that come due beyond PEND_MAX are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_gnt | input | 1 | Grant of the strobe bus from the access sequencer |
| bus_req | output | 1 | Request for the strobe bus |
| mem_ready | output | 1 | High once initialization is complete |
| strobe_oe | output | 1 | High while this block drives the strobes |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The grant is driven in five patterns. First it is held high from reset, through the pause, where it must have no effect. Then it follows the request with no delay, which pins down the refresh spacing. Then it is withheld over two and then over more than five refresh intervals. This separates a correct backlog from one that drops refreshes or never caps. Last it follows the request seven clocks late, which shows that a cycle waits for the grant. A reset in mid-run then checks that the pause restarts. A reference model holds the expected strobe waveform as a queue. It is compared with all outputs on every clock, so a wrong phase length or order shows up on the exact clock where it happens.

// File: rtl/dram_rfsh_pkg.sv
`timescale 1ns/1ps
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_CSU  = 3'd2,
        PH_RLO  = 3'd3,
        PH_CHI  = 3'd4,
        PH_REC  = 3'd5
    } cbr_phase_e;

    typedef enum logic [1:0] {
        MD_PAUSE = 2'd0,
        MD_INIT  = 2'd1,
        MD_RUN   = 2'd2
    } seq_mode_e;

    // Nanosecond limit to whole clocks, rounded up, never below one
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
`timescale 1ns/1ps
module dram_rfsh_timer #(
    parameter int PERIOD = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        tick     = en && (st_q.cnt == CW'(PERIOD - 1));
        st_d.cnt = (!en || tick) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (PERIOD > 1) begin : g_chk
            // a tick is never followed by another tick on the next clock
            assert_tick_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dram_rfsh_backlog.sv
`timescale 1ns/1ps
module dram_rfsh_backlog #(
    parameter int MAXCNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam int CW = $clog2(MAXCNT + 1);
    localparam logic [CW-1:0] TOP = CW'(MAXCNT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } blog_s;

    blog_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else begin
            case ({inc, dec})
                2'b10: if (st_q.cnt != TOP) st_d.cnt = st_q.cnt + 1'b1;
                2'b01: if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
                default: ;
            endcase
        end
        nonzero = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_backlog_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inc && !dec && st_q.cnt != TOP) |=> (st_q.cnt == $past(st_q.cnt) + CW'(1)));

    assert_backlog_caps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inc && !dec && st_q.cnt == TOP) |=> (st_q.cnt == TOP));

endmodule

// File: rtl/dram_rfsh_cbr_engine.sv
`timescale 1ns/1ps
module dram_rfsh_cbr_engine
    import dram_rfsh_pkg::*;
#(
    parameter int RP_CYC   = 2,
    parameter int CSR_CYC  = 1,
    parameter int CHR_CYC  = 1,
    parameter int RASL_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_lvl,
    output logic cas_lvl
);
    localparam int L_PRE = RP_CYC;
    localparam int L_CSU = CSR_CYC;
    localparam int L_RLO = CHR_CYC;
    localparam int L_CHI = (RASL_CYC > CHR_CYC) ? (RASL_CYC - CHR_CYC) : 1;
    localparam int L_REC = RP_CYC;
    localparam int L_M1  = (L_PRE > L_CSU) ? L_PRE : L_CSU;
    localparam int L_M2  = (L_RLO > L_CHI) ? L_RLO : L_CHI;
    localparam int L_MAX = (L_M1 > L_M2) ? L_M1 : L_M2;
    localparam int CW    = $clog2(L_MAX + 1);

    typedef struct packed {
        cbr_phase_e    phase;
        logic [CW-1:0] cnt;
    } eng_s;

    eng_s st_d, st_q;
    logic at_end;

    function automatic logic [CW-1:0] last_of(input cbr_phase_e p);
        case (p)
            PH_PRE:  return CW'(L_PRE - 1);
            PH_CSU:  return CW'(L_CSU - 1);
            PH_RLO:  return CW'(L_RLO - 1);
            PH_CHI:  return CW'(L_CHI - 1);
            PH_REC:  return CW'(L_REC - 1);
            default: return '0;
        endcase
    endfunction

    function automatic cbr_phase_e next_of(input cbr_phase_e p);
        case (p)
            PH_PRE:  return PH_CSU;
            PH_CSU:  return PH_RLO;
            PH_RLO:  return PH_CHI;
            PH_CHI:  return PH_REC;
            default: return PH_IDLE;
        endcase
    endfunction

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == last_of(st_q.phase));
        done   = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.phase = PH_PRE;
                st_d.cnt   = '0;
            end
        end else if (at_end) begin
            st_d.phase = next_of(st_q.phase);
            st_d.cnt   = '0;
            done       = (st_q.phase == PH_REC);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        busy    = (st_q.phase != PH_IDLE);
        ras_lvl = !((st_q.phase == PH_RLO) || (st_q.phase == PH_CHI));
        cas_lvl = !((st_q.phase == PH_CSU) || (st_q.phase == PH_RLO));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // RAS may only fall while CAS has already been low for a clock
    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_lvl) |-> (!cas_lvl && !$past(cas_lvl)));

    // CAS returns high while RAS is still low
    assert_cas_rises_under_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_lvl) |-> !ras_lvl);

    assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/dram_rfsh_seq.sv
`timescale 1ns/1ps
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int PAUSE_US     = 200,
    parameter int INIT_CYCLES  = 8,
    parameter int RETENTION_US = 32000,
    parameter int ROWS         = 2048,
    parameter int T_RP_NS      = 40,
    parameter int T_CSR_NS     = 5,
    parameter int T_CHR_NS     = 10,
    parameter int T_RAS_NS     = 60,
    parameter int PEND_MAX     = 3,
    parameter int NUM_RAS      = 4,
    parameter int NUM_CAS      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_gnt,
    output logic               bus_req,
    output logic               mem_ready,
    output logic               strobe_oe,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int REF_CYC   = (CLK_MHZ * RETENTION_US) / ROWS;
    localparam int RP_CYC    = ns_to_cycles(T_RP_NS, CLK_MHZ);
    localparam int CSR_CYC   = ns_to_cycles(T_CSR_NS, CLK_MHZ);
    localparam int CHR_CYC   = ns_to_cycles(T_CHR_NS, CLK_MHZ);
    localparam int RASL_CYC  = ns_to_cycles(T_RAS_NS, CLK_MHZ);
    localparam int IW        = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        seq_mode_e     mode;
        logic [IW-1:0] left;
        logic          ready;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic pause_tick, ref_tick, backlog_nz;
    logic eng_start, eng_busy, eng_done, eng_ras, eng_cas;

    dram_rfsh_timer #(.PERIOD(PAUSE_CYC)) u_pause (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.mode == MD_PAUSE), .tick(pause_tick)
    );

    dram_rfsh_timer #(.PERIOD(REF_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.mode == MD_RUN), .tick(ref_tick)
    );

    dram_rfsh_backlog #(.MAXCNT(PEND_MAX)) u_backlog (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.mode == MD_RUN),
        .inc(ref_tick), .dec(eng_done && (ctl_q.mode == MD_RUN)),
        .nonzero(backlog_nz)
    );

    dram_rfsh_cbr_engine #(
        .RP_CYC(RP_CYC), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RASL_CYC(RASL_CYC)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .busy(eng_busy),
        .done(eng_done), .ras_lvl(eng_ras), .cas_lvl(eng_cas)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.mode)
            MD_PAUSE: begin
                if (pause_tick) begin
                    ctl_d.mode = MD_INIT;
                    ctl_d.left = IW'(INIT_CYCLES);
                end
            end
            MD_INIT: begin
                if (eng_done) begin
                    if (ctl_q.left == IW'(1)) begin
                        ctl_d.mode  = MD_RUN;
                        ctl_d.ready = 1'b1;
                        ctl_d.left  = '0;
                    end else begin
                        ctl_d.left = ctl_q.left - 1'b1;
                    end
                end
            end
            default: ;
        endcase

        bus_req   = (ctl_q.mode == MD_INIT) || ((ctl_q.mode == MD_RUN) && backlog_nz);
        eng_start = bus_req && bus_gnt && !eng_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_ready = ctl_q.ready;
    assign strobe_oe = eng_busy;
    assign ras_n     = {NUM_RAS{eng_ras}};
    assign cas_n     = {NUM_CAS{eng_cas}};
    assign we_n      = 1'b1;

    assert_oe_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_oe |-> bus_req);

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> mem_ready);

    assert_quiet_in_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MD_PAUSE) |-> (!strobe_oe && !mem_ready));

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_oe && !eng_done) |=> bus_req);

endmodule

// File: tb/dram_rfsh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_seq_tb_top;

    localparam int MHZ       = 50;
    localparam int PAUSE_CYC = MHZ * 200;
    localparam int INIT_N    = 8;
    localparam int REF_CYC   = (MHZ * 32000) / 2048;
    localparam int PEND_MAX  = 3;
    localparam int RP        = (40 * MHZ + 999) / 1000;
    localparam int CSR       = ((5 * MHZ + 999) / 1000) < 1 ? 1 : (5 * MHZ + 999) / 1000;
    localparam int CHR       = ((10 * MHZ + 999) / 1000) < 1 ? 1 : (10 * MHZ + 999) / 1000;
    localparam int RASL      = (60 * MHZ + 999) / 1000;
    localparam int CHI       = (RASL > CHR) ? RASL - CHR : 1;
    localparam int DLY       = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_gnt = 1'b0;
    logic       bus_req, mem_ready, strobe_oe, we_n;
    logic [3:0] ras_n, cas_n;

    always #10 clk = ~clk;

    dram_rfsh_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .mem_ready(mem_ready), .strobe_oe(strobe_oe), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n)
    );

    // reference model: expected strobe waveform as a queue of {ras, cas}
    bit [1:0] exp_q[$];
    int m_mode, m_pcnt, m_init_left, m_tmr, m_pend;
    bit m_ready;

    int vectors = 0, miscompares = 0;
    int policy = 2;     // 0 prompt, 1 withhold, 2 always high, 3 delayed
    int req_age = 0;
    int cyc = 0;
    int first_req_cyc = -1, ready_cyc = -1;
    int init_starts = 0, win_starts = 0, last_start = -1;
    bit spacing_on = 0, oe_prev = 0, saw_start = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        exp_q.delete();
        m_mode = 0; m_pcnt = 0; m_init_left = 0; m_tmr = 0; m_pend = 0; m_ready = 0;
    endtask

    function automatic bit m_req();
        return (m_mode == 1) || (m_mode == 2 && m_pend > 0);
    endfunction

    task automatic push_cbr();
        for (int i = 0; i < RP; i++)   exp_q.push_back(2'b11);
        for (int i = 0; i < CSR; i++)  exp_q.push_back(2'b10);
        for (int i = 0; i < CHR; i++)  exp_q.push_back(2'b00);
        for (int i = 0; i < CHI; i++)  exp_q.push_back(2'b01);
        for (int i = 0; i < RP; i++)   exp_q.push_back(2'b11);
    endtask

    task automatic step_model(input bit g);
        bit idle, start, done, tick;
        idle  = (exp_q.size() == 0);
        start = m_req() && g && idle;
        done  = (exp_q.size() == 1);
        if (!idle) void'(exp_q.pop_front());
        if (start) push_cbr();
        case (m_mode)
            0: if (m_pcnt == PAUSE_CYC - 1) begin m_mode = 1; m_init_left = INIT_N; end
               else m_pcnt++;
            1: if (done) begin
                   m_init_left--;
                   if (m_init_left == 0) begin
                       m_mode = 2; m_ready = 1; m_tmr = 0; m_pend = 0;
                   end
               end
            default: begin
                tick  = (m_tmr == REF_CYC - 1);
                m_tmr = tick ? 0 : m_tmr + 1;
                if (tick && !done && m_pend < PEND_MAX) m_pend++;
                else if (!tick && done) m_pend--;
            end
        endcase
    endtask

    // action: 0 run, 1 hold reset, 2 release reset at this clock
    task automatic one_cycle(input int action);
        bit er, ec, eoe, g;
        @(negedge clk);
        if (rst_n) cyc++;
        er  = (exp_q.size() > 0) ? exp_q[0][1] : 1'b1;
        ec  = (exp_q.size() > 0) ? exp_q[0][0] : 1'b1;
        eoe = (exp_q.size() > 0);
        check(ras_n === {4{er}}, "R4", "ras_n", ras_n, {4{er}});
        check(cas_n === {4{ec}}, "R4", "cas_n", cas_n, {4{ec}});
        check(we_n === 1'b1, "R5", "we_n", we_n, 1);
        check(strobe_oe === eoe, "R6", "strobe_oe", strobe_oe, eoe);
        check(bus_req === m_req(), (m_mode == 0) ? "R2" : "R7", "bus_req", bus_req, m_req());
        check(mem_ready === m_ready, "R3", "mem_ready", mem_ready, m_ready);
        saw_start = 0;
        if (rst_n) begin
            if (bus_req && first_req_cyc < 0) first_req_cyc = cyc;
            if (mem_ready && ready_cyc < 0) ready_cyc = cyc;
            if (strobe_oe && !oe_prev) begin
                saw_start = 1;
                win_starts++;
                if (!mem_ready) init_starts++;
                if (spacing_on && last_start >= 0)
                    check(cyc - last_start == REF_CYC, "R8", "refresh spacing",
                          cyc - last_start, REF_CYC);
                last_start = cyc;
            end
        end
        oe_prev = strobe_oe;
        req_age = bus_req ? req_age + 1 : 0;
        case (policy)
            0: g = bus_req;
            1: g = 1'b0;
            2: g = 1'b1;
            default: g = bus_req && (req_age >= DLY);
        endcase
        bus_gnt = g;
        if (action == 1) begin
            rst_n = 1'b0;
            model_reset();
        end else begin
            if (action == 2) begin
                rst_n = 1'b1;
                cyc = 0; first_req_cyc = -1; ready_cyc = -1; init_starts = 0;
            end
            if (rst_n) step_model(g);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) one_cycle(0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL R6 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        policy = 2;                       // grant held high even without request (R6)
        repeat (3) one_cycle(1);
        check(ras_n === 4'hF && cas_n === 4'hF && !strobe_oe && !bus_req && !mem_ready,
              "R1", "reset state", {ras_n, cas_n}, 8'hFF);
        one_cycle(2);
        check(!strobe_oe && !bus_req && !mem_ready, "R1", "first cycle after reset",
              {strobe_oe, bus_req, mem_ready}, 0);
        run(PAUSE_CYC + 9 * INIT_N + 5);
        check(first_req_cyc == PAUSE_CYC, "R2", "first request cycle", first_req_cyc, PAUSE_CYC);
        check(init_starts == INIT_N, "R3", "init cycle count", init_starts, INIT_N);
        check(ready_cyc == PAUSE_CYC + 9 * INIT_N, "R3", "ready cycle",
              ready_cyc, PAUSE_CYC + 9 * INIT_N);

        // prompt grant: steady spacing (R8)
        policy = 0; spacing_on = 1; last_start = -1; win_starts = 0;
        run(4 * REF_CYC);
        check(win_starts == 4, "R8", "refreshes in four intervals", win_starts, 4);

        // withhold grant over two intervals: backlog of two (R9)
        spacing_on = 0;
        do one_cycle(0); while (!saw_start);
        policy = 1;
        run(2 * REF_CYC + REF_CYC / 2);
        check(!strobe_oe && bus_req, "R9", "request pending while withheld",
              {strobe_oe, bus_req}, 1);
        policy = 0; win_starts = 0;
        run(REF_CYC / 4);
        check(win_starts == 2, "R9", "backlog burst", win_starts, 2);

        // withhold over six dues: capped at PEND_MAX (R9)
        policy = 1;
        run(5 * REF_CYC + REF_CYC / 2);
        policy = 0; win_starts = 0;
        run(REF_CYC / 4);
        check(win_starts == PEND_MAX, "R9", "saturated burst", win_starts, PEND_MAX);

        // late grant: cycles wait for grant (R6)
        policy = 3; win_starts = 0;
        run(2 * REF_CYC);
        check(win_starts == 2, "R6", "starts under delayed grant", win_starts, 2);

        // reset mid-run restarts the pause (R1, R2)
        policy = 0;
        one_cycle(1);
        one_cycle(1);
        check(ras_n === 4'hF && cas_n === 4'hF && !strobe_oe && !bus_req && !mem_ready,
              "R1", "reset state mid-run", {ras_n, cas_n}, 8'hFF);
        one_cycle(2);
        run(50);
        check(first_req_cyc < 0 && !mem_ready, "R2", "no request early after reset",
              first_req_cyc, -1);

        summary();
        $finish;
    end

endmodule